// File: doc/BRIEF.md
# Serial Byte Transmitter with Early Completion Strobe

This block shifts bytes out on an asynchronous serial line, one frame per byte: a low start bit, eight data bits least significant first, and a single high stop bit, with no parity. It is meant to sit directly behind a show-ahead byte buffer. The buffer drives the byte input with its head entry and raises the start request whenever it holds data. The transmitter pulses its completion strobe a fixed number of clocks before the stop bit ends. The buffer uses that strobe to pop its head, so the next byte is on the byte input when the stop bit finishes. While the request stays high, frames follow one another with no idle time on the line.

Each bit lasts a whole number of clock cycles set by a parameter. The strobe lead is also a parameter and must be smaller than the bit length. The synchronous reset is the only way to abort a frame; the host's clear commands are expected to be OR-ed into it.

Top module: `serial_frame_tx`

## Requirements
- R1: While reset is sampled high at a clock edge, the line is high after that edge, the busy flag is low and the completion strobe is low.
- R2: A frame is a low start bit, then the eight data bits with bit 0 first, then a high stop bit. Each bit holds the line for exactly BIT_CYCLES clock cycles, so a frame is 10*BIT_CYCLES cycles.
- R3: When no frame is in progress, the line stays high.
- R4: The busy flag is high from the first cycle of the start bit through the last cycle of the stop bit, and is low otherwise.
- R5: The completion strobe is high for exactly one cycle per frame. That cycle is the stop-bit cycle with index BIT_CYCLES-1-DONE_LEAD, counted from 0. The line is high and the busy flag is high in that cycle.
- R6: The byte is captured at the clock edge that starts the frame. Changes on the byte input after that edge have no effect on the bits sent.
- R7: If the start request is high at the edge that ends the stop bit, the next start bit begins right after that edge, with the byte then on the input. The busy flag does not drop between the two frames.
- R8: A reset asserted in the middle of a frame abandons it. At the next edge the line returns high and the busy flag goes low.
- R9: From idle, a start request sampled high at a clock edge drives the line low and the busy flag high right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also used to abort a frame |
| start_req | input | 1 | Level request: a byte is available on tx_byte |
| tx_byte | input | 8 | Byte to send, captured when a frame starts |
| tx_line | output | 1 | Serial output, high when idle |
| tx_active | output | 1 | High while a frame is being sent |
| tx_done | output | 1 | One-cycle strobe placed DONE_LEAD cycles before the stop bit ends |

## Verification
Each output is a decode of registers. It therefore changes directly after the clock edge at which the request, the reset or a bit boundary is sampled. The line goes low in the cycle right after an accepted request, and each later bit boundary falls a multiple of BIT_CYCLES cycles after that. The strobe is due 10*BIT_CYCLES-1-DONE_LEAD cycles after the frame starts. The bench drives inputs one nanosecond after the rising edge. On every edge it advances its own frame-position model and compares all three outputs at the following falling edge, which is one cycle after the stimulus that caused the change. Directed sequences decode a frame at mid-bit positions, measure the back-to-back spacing and abort a frame with reset.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    // Frame phase of the transmitter
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } sertx_phase_e;

    localparam int unsigned FRAME_DATA_BITS = 8;

    // Level driven on the serial line for a given phase
    function automatic logic line_level(input sertx_phase_e ph, input logic data_lsb);
        logic lvl;
        case (ph)
            PH_START: lvl = 1'b0;
            PH_DATA:  lvl = data_lsb;
            default:  lvl = 1'b1;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
    parameter int unsigned BIT_CYCLES = 16,
    parameter int unsigned DONE_LEAD  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic bit_end,
    output logic early_mark
);
    localparam int unsigned CNT_W    = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
    localparam int unsigned LAST_CNT = BIT_CYCLES - 1;
    localparam int unsigned MARK_CNT = BIT_CYCLES - 1 - DONE_LEAD;

    logic [CNT_W-1:0] cnt_q;

    assign bit_end    = run && (cnt_q == CNT_W'(LAST_CNT));
    assign early_mark = run && (cnt_q == CNT_W'(MARK_CNT));

    always_ff @(posedge clk) begin
        if (rst || !run || bit_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] data_in,
    output logic             lsb_out
);
    logic [WIDTH-1:0] sh_q;

    assign lsb_out = sh_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '1;
        end else if (load) begin
            sh_q <= data_in;
        end else if (shift) begin
            sh_q <= {1'b1, sh_q[WIDTH-1:1]};
        end
    end
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
    import sertx_pkg::*;
#(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_req,
    input  logic         bit_end,
    output sertx_phase_e phase,
    output logic         load,
    output logic         shift
);
    localparam int unsigned IDX_W    = (DATA_BITS > 2) ? $clog2(DATA_BITS) : 1;
    localparam int unsigned LAST_IDX = DATA_BITS - 1;

    sertx_phase_e     phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    assign phase = phase_q;

    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        load    = 1'b0;
        shift   = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (start_req) begin
                    phase_d = PH_START;
                    load    = 1'b1;
                end
            end
            PH_START: begin
                if (bit_end) begin
                    phase_d = PH_DATA;
                    idx_d   = '0;
                end
            end
            PH_DATA: begin
                if (bit_end) begin
                    shift = 1'b1;
                    if (idx_q == IDX_W'(LAST_IDX)) begin
                        phase_d = PH_STOP;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            PH_STOP: begin
                if (bit_end) begin
                    if (start_req) begin
                        phase_d = PH_START;
                        load    = 1'b1;
                    end else begin
                        phase_d = PH_IDLE;
                    end
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
        end
    end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sertx_pkg::*;
#(
    parameter int unsigned BIT_CYCLES = 16,
    parameter int unsigned DONE_LEAD  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req,
    input  logic [7:0] tx_byte,
    output logic       tx_line,
    output logic       tx_active,
    output logic       tx_done
);
    sertx_phase_e phase;
    logic         load, shift, bit_end, early_mark, data_lsb;

    sertx_ctrl #(.DATA_BITS(FRAME_DATA_BITS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .bit_end   (bit_end),
        .phase     (phase),
        .load      (load),
        .shift     (shift)
    );

    sertx_bit_timer #(.BIT_CYCLES(BIT_CYCLES), .DONE_LEAD(DONE_LEAD)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .run        (tx_active),
        .bit_end    (bit_end),
        .early_mark (early_mark)
    );

    sertx_shifter #(.WIDTH(FRAME_DATA_BITS)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .shift   (shift),
        .data_in (tx_byte),
        .lsb_out (data_lsb)
    );

    assign tx_active = (phase != PH_IDLE);
    assign tx_line   = line_level(phase, data_lsb);
    assign tx_done   = (phase == PH_STOP) && early_mark;
endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk (
    input logic clk,
    input logic rst,
    input logic start_req,
    input logic tx_line,
    input logic tx_active,
    input logic tx_done
);
    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    // R1 / R8: outputs after an edge with reset sampled high
    always @(posedge clk) begin
        if (rst_seen_q === 1'b1) begin
            assert_reset_idle_R1: assert (tx_line && !tx_active && !tx_done)
                else $error("reset state violated");
        end
    end

    assert_idle_line_high_R3: assert property (@(posedge clk) disable iff (rst)
        !tx_active |-> tx_line);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !tx_done);

    assert_done_in_stop_R5: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (tx_active && tx_line));

    assert_start_latency_R9: assert property (@(posedge clk) disable iff (rst)
        (!tx_active && start_req) |=> (tx_active && !tx_line));

    assert_fall_only_busy_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_line) |-> tx_active);
endmodule

bind serial_frame_tx serial_frame_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .tx_line   (tx_line),
    .tx_active (tx_active),
    .tx_done   (tx_done)
);

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb;
    localparam int unsigned BC   = 6;
    localparam int unsigned LEAD = 2;
    localparam int unsigned FRM  = 10 * BC;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_req = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_line, tx_active, tx_done;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    int unsigned cyc_count = 0;
    bit          model_on = 1'b0;

    // bench model of the frame position
    bit          m_busy = 1'b0;
    int unsigned m_pos  = 0;
    logic [7:0]  m_byte = 8'h00;

    serial_frame_tx #(.BIT_CYCLES(BC), .DONE_LEAD(LEAD)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .tx_byte   (tx_byte),
        .tx_line   (tx_line),
        .tx_active (tx_active),
        .tx_done   (tx_done)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_line(input bit busy, input int unsigned pos, input logic [7:0] b);
        if (!busy) return 1'b1;
        if (pos < BC) return 1'b0;
        if (pos < 9 * BC) return b[(pos - BC) / BC];
        return 1'b1;
    endfunction

    function automatic logic exp_done(input bit busy, input int unsigned pos);
        return busy && (pos == FRM - 1 - LEAD);
    endfunction

    always @(posedge clk) begin
        cyc_count <= cyc_count + 1;
        model_on  <= 1'b1;
        if (rst) begin
            m_busy <= 1'b0;
            m_pos  <= 0;
        end else if (!m_busy) begin
            if (start_req) begin
                m_busy <= 1'b1;
                m_pos  <= 0;
                m_byte <= tx_byte;
            end
        end else if (m_pos == FRM - 1) begin
            if (start_req) begin
                m_pos  <= 0;
                m_byte <= tx_byte;
            end else begin
                m_busy <= 1'b0;
            end
        end else begin
            m_pos <= m_pos + 1;
        end
    end

    always @(negedge clk) begin
        if (model_on) begin
            check(tx_line === exp_line(m_busy, m_pos, m_byte), "R2 line level",
                  32'(tx_line), 32'(exp_line(m_busy, m_pos, m_byte)));
            check(tx_active === m_busy, "R4 busy flag", 32'(tx_active), 32'(m_busy));
            check(tx_done === exp_done(m_busy, m_pos), "R5 done strobe",
                  32'(tx_done), 32'(exp_done(m_busy, m_pos)));
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary_and_end();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc_count > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary_and_end();
        end
    end

    initial begin
        logic [7:0] rx;
        int unsigned gaps;
        void'($urandom(32'd20211));

        // R1: reset state
        step(3);
        @(negedge clk);
        check(tx_line === 1'b1 && tx_active === 1'b0 && tx_done === 1'b0, "R1 reset state",
              {29'd0, tx_line, tx_active, tx_done}, 32'b100);
        #1;
        rst = 1'b0;
        step(4);
        // R3: idle without request
        @(negedge clk);
        check(tx_line === 1'b1 && tx_active === 1'b0, "R3 idle line", 32'(tx_line), 32'd1);

        // R6 and R9: single frame, byte changed during the frame
        @(posedge clk); #1;
        start_req = 1'b1; tx_byte = 8'h3C;
        @(posedge clk); #1;
        start_req = 1'b0;
        rx = 8'h00;
        for (int k = 0; k < int'(FRM); k++) begin
            @(negedge clk);
            if (k == 0) check(tx_line === 1'b0 && tx_active === 1'b1, "R9 start latency",
                              32'(tx_line), 32'd0);
            for (int i = 0; i < 8; i++)
                if (k == int'(BC) * (1 + i) + int'(BC) / 2) rx[i] = tx_line;
            tx_byte = 8'($urandom);
        end
        check(rx === 8'h3C, "R6 byte captured at start", 32'(rx), 32'h3C);
        step(3);

        // R7: request held high streams frames back to back
        @(posedge clk); #1;
        start_req = 1'b1; tx_byte = 8'hA5;
        gaps = 0;
        for (int k = 0; k < int'(3 * FRM); k++) begin
            @(negedge clk);
            if (k > 0 && tx_active !== 1'b1) gaps++;
            if (k == int'(FRM) / 2) tx_byte = 8'h5A;
        end
        check(gaps == 0, "R7 no gap between frames", gaps, 0);
        start_req = 1'b0;
        step(int'(FRM) + 2);

        // R8: reset in the middle of a frame
        @(posedge clk); #1;
        start_req = 1'b1; tx_byte = 8'h00;
        @(posedge clk); #1;
        start_req = 1'b0;
        step(3 * BC);
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(tx_line === 1'b1 && tx_active === 1'b0, "R8 abort on reset",
              {30'd0, tx_line, tx_active}, 32'b10);
        step(2);

        // Random traffic checked by the frame model (R2, R4, R5, R7)
        for (int c = 0; c < 4000; c++) begin
            start_req = ($urandom % 4) != 0;
            tx_byte   = 8'($urandom);
            rst       = ($urandom % 500) == 0;
            step(1);
        end
        rst = 1'b0; start_req = 1'b0;
        step(int'(FRM) + 4);
        summary_and_end();
    end
endmodule